// File: doc/BRIEF.md
# Dual-Slope / Single-Slope PWM Timer

This block is an 8-bit timer with a clock divider and one compare channel that drives a single waveform pin. It has two waveform shapes. In single-slope mode the counter runs from 0 up to its top value (255) and wraps back to 0. In dual-slope mode the counter climbs from 0 to 255 and then descends to 0, so the pulse stays centred in each period. Dual-slope mode suits motor drives, where pulses must stay symmetric.

Software writes a compare value through a strobe. The value lands in a holding register and is copied into the active compare register only at a period boundary, so a duty change never cuts a pulse short. A 2-bit output-action code sets the pin behaviour: off, toggle, normal polarity or inverted polarity. A 3-bit divider code sets how often the counter steps. The current count and a one-clock match pulse are also outputs.

Top module: `pwm8_timer`

## Requirements
- R1: While `rst` is high, `count_o`, `pwm_o` and `match_o` are all 0. The count starts at 0 going upward, so the first step after reset is to 1.
- R2: `clk_sel_i` sets the step interval. Code 1 steps every clock, code 2 every 8 clocks, code 3 every 64, code 4 every 256 and code 5 every 1024. Codes 0, 6 and 7 freeze the counter.
- R3: With `mode_i`=0 (single slope), each step raises the count by one, and 255 is followed by 0.
- R4: In single slope with `out_mode_i`=2, the pin goes high at the 255→0 step. It goes low on the step that leaves the compare value K. In steady state, the pin is high exactly while count ≤ K: compare 0 gives a one-step spike every 256 steps, and compare 255 gives a constant high. `out_mode_i`=3 gives the exact complement.
- R5: In single slope with `out_mode_i`=1, the pin inverts on every step that leaves count K, and holds otherwise.
- R6: With `mode_i`=1 (dual slope), the count runs 0,1,…,254,255,254,…,1 and repeats. This is a 510-step period in which 255 and 0 each occur once.
- R7: In dual slope with `out_mode_i`=2, the pin goes low on the step leaving K on the rising slope, and goes high on the step leaving K on the falling slope. The value 255 counts as falling and 0 as rising. In steady state the pin is high for 2·K steps per period. Compare 0 gives a constant low and 255 a constant high. `out_mode_i`=3 gives the complement.
- R8: A written compare value becomes active only at a boundary. In single slope that is the 255→0 step. In dual slope it is the step that reaches 255. Until then the old value governs the pin and the match flag.
- R9: `out_mode_i`=0 holds the pin at 0. In dual slope, `out_mode_i`=1 also holds the pin at 0.
- R10: `match_o` is high for exactly the one clock that follows each step leaving a count equal to the active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = single slope, 1 = dual slope |
| out_mode_i | input | 2 | 0 off, 1 toggle, 2 normal, 3 inverted |
| clk_sel_i | input | 3 | Step-interval select (see R2) |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_data_i | input | CNT_W | Compare value to write |
| pwm_o | output | 1 | Waveform pin (registered) |
| count_o | output | CNT_W | Current count (registered) |
| match_o | output | 1 | One-clock compare match pulse (registered) |

## Verification
The count, the pin and the match flag are all registered, and all three change on the same rising edge: the one at which a divider step occurs. The bench therefore samples every output on the falling edge that follows a step. Each sample is judged against the count seen at the previous falling edge, because the pin action and the match belong to the value being left. A compare write takes effect at the next boundary, and the pin settles one full period after that. For this reason the bench waits one boundary plus one period before it starts a steady-state sweep. The double-buffer tests probe the count values that lie between the write and the boundary. Divider checks count falling edges between successive count changes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NORMAL = 2'd2,
    OUT_INVERT = 2'd3
  } out_mode_e;

  typedef enum logic {
    SLOPE_SINGLE = 1'b0,
    SLOPE_DUAL   = 1'b1
  } slope_e;

  localparam int SEL_W = 3;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [pwm_pkg::SEL_W-1:0] sel_i,
  output logic                      tick_o
);
  localparam logic [DIV_W-1:0] M_DIV8    = DIV_W'(7);
  localparam logic [DIV_W-1:0] M_DIV64   = DIV_W'(63);
  localparam logic [DIV_W-1:0] M_DIV256  = DIV_W'(255);
  localparam logic [DIV_W-1:0] M_DIV1024 = DIV_W'(1023);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             run;

  always_comb begin
    run  = 1'b1;
    mask = '0;
    case (sel_i)
      3'd1:    mask = '0;
      3'd2:    mask = M_DIV8;
      3'd3:    mask = M_DIV64;
      3'd4:    mask = M_DIV256;
      3'd5:    mask = M_DIV1024;
      default: run  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      div_q <= '0;
    else if (run) div_q <= div_q + DIV_W'(1);
  end

  assign tick_o = run && ((div_q & mask) == mask);

  assert_div8_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 3'd2 && tick_o) ##1 (sel_i == 3'd2) |-> !tick_o);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             dual_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] TOP_M1 = TOP - CNT_W'(1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d;

  always_comb begin
    cnt_d  = cnt_q;
    dn_d   = dn_q;
    load_o = 1'b0;
    if (tick_i) begin
      if (!dual_i) begin
        cnt_d  = cnt_q + ONE;
        dn_d   = 1'b0;
        load_o = (cnt_q == TOP);
      end else if (!dn_q) begin
        if (cnt_q >= TOP_M1) begin
          cnt_d  = (cnt_q == TOP) ? TOP_M1 : TOP;
          dn_d   = 1'b1;
          load_o = (cnt_q == TOP_M1);
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d = '0;
          dn_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = dn_q;

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !dual_i) |=> (cnt_q == $past(cnt_q) + ONE));
  assert_peak_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && dual_i && cnt_q == TOP) |=> (cnt_q == TOP_M1));
  assert_floor_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && dual_i && cnt_q == '0) |=> (cnt_q == ONE));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             dual_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             load_i,
  input  logic [1:0]       out_mode_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             match_o
);
  import pwm_pkg::*;

  localparam logic [CNT_W-1:0] TOP = '1;

  out_mode_e        om;
  logic [CNT_W-1:0] hold_q, act_q;
  logic             wave_q, wave_d, match_q;
  logic             hit, inv, linked;

  assign om     = out_mode_e'(out_mode_i);
  assign hit    = tick_i && (cnt_i == act_q);
  assign inv    = (om == OUT_INVERT);
  assign linked = (om == OUT_NORMAL) || (om == OUT_INVERT) ||
                  (om == OUT_TOGGLE && !dual_i);

  always_comb begin
    wave_d = wave_q;
    if (!linked) begin
      wave_d = 1'b0;
    end else if (om == OUT_TOGGLE) begin
      if (hit) wave_d = !wave_q;
    end else if (!dual_i) begin
      if (tick_i && cnt_i == TOP) wave_d = !inv;
      else if (hit)               wave_d = inv;
    end else begin
      if (hit) wave_d = down_i ? !inv : inv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      act_q   <= '0;
      wave_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (wr_i)   hold_q <= wr_data_i;
      if (load_i) act_q  <= hold_q;
      wave_q  <= wave_d;
      match_q <= hit;
    end
  end

  assign pwm_o   = wave_q;
  assign match_o = match_q;

  assert_active_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(act_q));
  assert_off_low_R9: assert property (@(posedge clk) disable iff (rst)
    (om == OUT_OFF) |=> !pwm_o);
  assert_wrap_high_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !dual_i && om == OUT_NORMAL && cnt_i == TOP) |=> pwm_o);
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic [1:0]       out_mode_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic             tick, down, load;
  logic [CNT_W-1:0] cnt;

  pwm_prescale #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .sel_i(clk_sel_i), .tick_o(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .dual_i(mode_i),
    .cnt_o(cnt), .down_o(down), .load_o(load)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .tick_i(tick), .dual_i(mode_i), .down_i(down),
    .cnt_i(cnt), .load_i(load), .out_mode_i(out_mode_i),
    .wr_i(cmp_wr_i), .wr_data_i(cmp_data_i),
    .pwm_o(pwm_o), .match_o(match_o)
  );

  assign count_o = cnt;
endmodule

// File: tb/sim_pwm8_timer.sv
`timescale 1ns/1ps
module sim_pwm8_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] out_mode_i = 2'd2;
  logic [2:0] clk_sel_i = 3'd1;
  logic       cmp_wr_i = 1'b0;
  logic [7:0] cmp_data_i = 8'd0;
  logic       pwm_o, match_o;
  logic [7:0] count_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwm8_timer u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .out_mode_i(out_mode_i),
    .clk_sel_i(clk_sel_i), .cmp_wr_i(cmp_wr_i), .cmp_data_i(cmp_data_i),
    .pwm_o(pwm_o), .count_o(count_o), .match_o(match_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input int k);
    @(negedge clk);
    cmp_wr_i   = 1'b1;
    cmp_data_i = 8'(k);
    @(negedge clk);
    cmp_wr_i   = 1'b0;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (count_o == 8'(v)) break;
    end
  endtask

  function automatic bit single_lvl(input int v, input int k);
    return v <= k;
  endfunction

  function automatic bit dual_lvl(input int v, input bit up, input int k);
    if (k == 0)   return 1'b0;
    if (k == 255) return 1'b1;
    return up ? (v <= k) : (v < k);
  endfunction

  task automatic observe(input int n, input bit dual, input int om, input int k);
    int prev, v, e;
    bit prev_up, up, ppin, ep;
    string rq;
    @(negedge clk); prev = count_o;
    @(negedge clk); v = count_o;
    prev_up = (v == 0) ? 1'b1 : (v == 255) ? 1'b0 : (v > prev);
    prev = v; ppin = pwm_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v = count_o;
      if (!dual) e = (prev + 1) % 256;
      else       e = prev_up ? prev + 1 : prev - 1;
      chk(v == e, dual ? "R6" : "R3", v, e);
      up = (v == 255) ? 1'b0 : (v == 0) ? 1'b1 : prev_up;
      if (om == 0 || (om == 1 && dual)) begin
        ep = 1'b0; rq = "R9";
      end else if (om == 1) begin
        ep = (prev == k) ? !ppin : ppin; rq = "R5";
      end else if (dual) begin
        ep = dual_lvl(v, up, k) ^ (om == 3); rq = "R7";
      end else begin
        ep = single_lvl(v, k) ^ (om == 3); rq = "R4";
      end
      chk(pwm_o == ep, rq, pwm_o, ep);
      chk(match_o == (prev == k), "R10", match_o, (prev == k));
      prev = v; prev_up = up; ppin = pwm_o;
    end
  endtask

  task automatic run_cfg(input bit dual, input int om, input int k);
    write_cmp(k);
    mode_i     = dual;
    out_mode_i = 2'(om);
    repeat (dual ? 1100 : 600) @(negedge clk);
    observe(dual ? 520 : 260, dual, om, k);
  endtask

  task automatic measure_div(input int sel, input int n);
    int c;
    logic [7:0] v0;
    @(negedge clk);
    clk_sel_i = 3'(sel);
    v0 = count_o;
    for (int i = 0; i < 2 * n + 4; i++) begin
      @(negedge clk);
      if (count_o != v0) break;
    end
    v0 = count_o;
    c  = 0;
    for (int i = 0; i < 2 * n + 4; i++) begin
      @(negedge clk);
      c++;
      if (count_o != v0) break;
    end
    chk(c == n, "R2", c, n);
  endtask

  initial begin
    int lst[6] = '{0, 1, 37, 128, 254, 255};
    logic [7:0] v0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(count_o == 0, "R1", count_o, 0);
    chk(pwm_o == 0, "R1", pwm_o, 0);
    chk(match_o == 0, "R1", match_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(count_o == 1, "R1", count_o, 1);

    for (int p = 0; p < 2; p++)
      for (int om = 2; om < 4; om++)
        foreach (lst[j]) run_cfg(p[0], om, lst[j]);

    run_cfg(1'b0, 1, 0);
    run_cfg(1'b0, 1, 37);
    run_cfg(1'b0, 0, 128);
    run_cfg(1'b1, 0, 128);
    run_cfg(1'b1, 1, 90);

    // R8: single-slope double buffering
    out_mode_i = 2'd2;
    run_cfg(1'b0, 2, 200);
    wait_count(100);
    write_cmp(50);
    wait_count(150);
    chk(pwm_o == 1'b1, "R8", pwm_o, 1);
    wait_count(0);
    wait_count(150);
    chk(pwm_o == 1'b0, "R8", pwm_o, 0);

    // R8: dual-slope double buffering
    run_cfg(1'b1, 2, 200);
    wait_count(255);
    wait_count(100);
    write_cmp(50);
    wait_count(0);
    wait_count(150);
    chk(pwm_o == 1'b1, "R8", pwm_o, 1);
    wait_count(255);
    wait_count(150);
    chk(pwm_o == 1'b0, "R8", pwm_o, 0);

    // R2: divider intervals and stop codes
    mode_i = 1'b0;
    measure_div(2, 8);
    measure_div(3, 64);
    measure_div(4, 256);
    measure_div(5, 1024);
    measure_div(1, 1);
    foreach (lst[j]) begin
      if (j > 2) break;
      @(negedge clk);
      clk_sel_i = (j == 0) ? 3'd0 : (j == 1) ? 3'd6 : 3'd7;
      @(negedge clk);
      v0 = count_o;
      repeat (300) @(negedge clk);
      chk(count_o == v0, "R2", count_o, v0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule